// File: doc/BRIEF.md
# Interrupt Coalescing Counter and Delay Timer

This block reduces the interrupt rate of one DMA channel. Each end-of-frame completion steps a down-counter that was loaded from a programmable threshold. When the count runs out, a completion interrupt is latched and the counter starts over from the threshold. Each completion also restarts a delay timer from a programmable value. The timer steps down on an external tick enable. When it expires, a delay interrupt is latched and the completion counter starts over. This way a trickle of frames that never reaches the threshold still gets serviced.

Both interrupt kinds are latched in a pending vector. Software clears them one bit at a time with a clear strobe. The pending vector is masked with per-kind enables to drive one interrupt line. The live counter and timer values are brought out for a status read. Register decode and descriptor handling sit outside the block. Pending bit 0 is the completion interrupt and pending bit 1 is the delay interrupt. The same bit positions apply to the enable and clear vectors.

Top module: `irqc_coalescer`

## Requirements
- R1: After a synchronous reset, count_now, timer_now and pending are all zero and irq is low.
- R2: A cfg_write loads the counter with cfg_threshold on the next edge. It takes precedence over any completion or timer expiry in the same cycle.
- R3: A completion (done_strobe) while the counter is above 1 lowers the counter by one.
- R4: A completion while the counter is 0 or 1 sets pending bit 0 and reloads the counter with cfg_threshold. A threshold of 0 therefore raises the interrupt on every completion.
- R5: A completion while cfg_delay is nonzero loads the timer with cfg_delay. A tick in that same cycle has no effect.
- R6: A completion while cfg_delay is zero leaves the timer value unchanged. A tick in that same cycle has no effect.
- R7: A tick without a completion lowers a nonzero timer by one. A zero timer stays at zero. Without a tick, the timer holds its value.
- R8: A tick that takes the timer from 1 to 0 without a completion sets pending bit 1 and reloads the counter with cfg_threshold.
- R9: A clr_strobe bit clears the matching pending bit. If that bit is set in the same cycle, the set wins.
- R10: irq is high exactly when some pending bit and the enable bit at the same position are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_threshold | input | 8 | Completions per completion interrupt |
| cfg_delay | input | 8 | Timer start value in ticks, 0 = no restart |
| cfg_write | input | 1 | Control-register write strobe, reloads the counter |
| irq_en | input | 2 | Interrupt enables, bit 0 completion, bit 1 delay |
| done_strobe | input | 1 | One end-of-frame completion |
| clr_strobe | input | 2 | Write-one-to-clear strobes for the pending bits |
| tick | input | 1 | Timer step enable |
| irq | output | 1 | Channel interrupt line |
| pending | output | 2 | Latched interrupt kinds |
| count_now | output | 8 | Live completion counter |
| timer_now | output | 8 | Live delay timer |

## Verification
The bench sweeps thresholds 0 to 5, delays 0 to 3 and every enable pattern. Pseudo-random completions, ticks, clears and control writes are compared each cycle against a model built from the requirements.

The sweep targets these corner cases and the failures they expose:
- Thresholds 0 and 1: a design that wraps a zero counter would go silent for 255 frames.
- A completion and a tick in the same cycle: a design that lets the tick through would expire one tick early.
- A clear and a set of the same bit together: a design where the clear wins would lose an interrupt.
- A zero delay: a design that loads it would stop the running timer.
- Timer expiry: a design that skips the counter reload would raise the next completion interrupt too early.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int CNT_W     = 8;
    localparam int TMR_W     = 8;
    localparam int NUM_KINDS = 2;
    localparam int KIND_DONE = 0;
    localparam int KIND_DLY  = 1;

    typedef logic [NUM_KINDS-1:0] kind_vec_t;

    typedef struct packed {
        logic done_hit;
        logic dly_hit;
    } irqc_evt_t;

    function automatic kind_vec_t evt_to_vec(irqc_evt_t e);
        kind_vec_t v;
        v = '0;
        v[KIND_DONE] = e.done_hit;
        v[KIND_DLY]  = e.dly_hit;
        return v;
    endfunction
endpackage

// File: rtl/irqc_frame_counter.sv
module irqc_frame_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] threshold,
    input  logic         cfg_write,
    input  logic         done,
    input  logic         expire,
    output logic [W-1:0] count,
    output logic         hit
);
    localparam logic [W-1:0] ONE = W'(1);

    assign hit = done && (count <= ONE);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (cfg_write)
            count <= threshold;
        else if (done)
            count <= hit ? threshold : count - ONE;
        else if (expire)
            count <= threshold;
    end

    // R2
    cfg_reload_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_write |=> count == $past(threshold));
    // R3
    cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !cfg_write && count > ONE) |=> count == $past(count) - ONE);
endmodule

// File: rtl/irqc_delay_timer.sv
module irqc_delay_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] delay,
    input  logic         done,
    input  logic         tick,
    output logic [W-1:0] value,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    assign expire = tick && !done && (value == ONE);

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (done) begin
            if (delay != '0)
                value <= delay;
        end else if (tick && value != '0)
            value <= value - ONE;
    end

    // R5
    tmr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (done && delay != '0) |=> value == $past(delay));
    // R6
    tmr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && delay == '0) |=> $stable(value));
    // R7
    tmr_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !done && value != '0) |=> value == $past(value) - ONE);
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] pend,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend[i] <= 1'b0;
            else
                pend[i] <= set[i] | (pend[i] & ~clr[i]);
        end

        // R9
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> pend[i]);
    end

    assign irq = |(pend & en);
endmodule

// File: rtl/irqc_coalescer.sv
module irqc_coalescer
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_threshold,
    input  logic [TMR_W-1:0] cfg_delay,
    input  logic             cfg_write,
    input  logic [1:0]       irq_en,
    input  logic             done_strobe,
    input  logic [1:0]       clr_strobe,
    input  logic             tick,
    output logic             irq,
    output logic [1:0]       pending,
    output logic [CNT_W-1:0] count_now,
    output logic [TMR_W-1:0] timer_now
);
    irqc_evt_t evt;
    logic      expire;
    logic      cnt_hit;

    irqc_delay_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .delay(cfg_delay), .done(done_strobe),
        .tick(tick), .value(timer_now), .expire(expire)
    );

    irqc_frame_counter #(.W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .threshold(cfg_threshold), .cfg_write(cfg_write),
        .done(done_strobe), .expire(expire), .count(count_now), .hit(cnt_hit)
    );

    always_comb begin
        evt.done_hit = cnt_hit;
        evt.dly_hit  = expire;
    end

    irqc_pending #(.N(NUM_KINDS)) u_pend (
        .clk(clk), .rst(rst), .set(evt_to_vec(evt)), .clr(clr_strobe),
        .en(irq_en), .pend(pending), .irq(irq)
    );

    // R8
    dly_reload_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> (pending[KIND_DLY] && count_now == $past(cfg_threshold)));
    // R4
    done_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (done_strobe && count_now <= CNT_W'(1)) |=> pending[KIND_DONE]);
endmodule

// File: tb/test_irqc_coalescer.sv
module test_irqc_coalescer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] cfg_threshold, cfg_delay;
    logic       cfg_write, done_strobe, tick;
    logic [1:0] irq_en, clr_strobe;
    logic       irq;
    logic [1:0] pending;
    logic [7:0] count_now, timer_now;

    int n_checks = 0;
    int n_errors = 0;

    int       m_cnt, m_tmr;
    bit [1:0] m_pend;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_coalescer i_irqc_coalescer (
        .clk(clk), .rst(rst), .cfg_threshold(cfg_threshold), .cfg_delay(cfg_delay),
        .cfg_write(cfg_write), .irq_en(irq_en), .done_strobe(done_strobe),
        .clr_strobe(clr_strobe), .tick(tick), .irq(irq), .pending(pending),
        .count_now(count_now), .timer_now(timer_now)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock with the given inputs, then model update and compare
    task automatic step(bit w, bit d, bit t, bit [1:0] clr);
        bit expire, ioc;
        string ctag, ttag;
        cfg_write = w; done_strobe = d; tick = t; clr_strobe = clr;
        @(posedge clk);
        #1;
        expire = t && !d && (m_tmr == 1);
        ioc    = d && (m_cnt <= 1);
        if (w)           begin m_cnt = cfg_threshold; ctag = "R2"; end
        else if (d)      begin
            if (ioc) begin m_cnt = cfg_threshold; ctag = "R4"; end
            else     begin m_cnt = m_cnt - 1; ctag = "R3"; end
        end
        else if (expire) begin m_cnt = cfg_threshold; ctag = "R8"; end
        else ctag = "R3";
        if (d && cfg_delay != 0) begin m_tmr = cfg_delay; ttag = "R5"; end
        else if (d) ttag = "R6";
        else begin
            if (t && m_tmr != 0) m_tmr = m_tmr - 1;
            ttag = "R7";
        end
        m_pend = (m_pend & ~clr) | {expire, ioc};
        check(ctag, count_now, m_cnt);
        check(ttag, timer_now, m_tmr);
        check(expire ? "R8" : (ioc ? "R4" : "R9"), pending, m_pend);
        check("R10", irq, |(m_pend & irq_en));
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_threshold = 8'd3; cfg_delay = 8'd2; cfg_write = 0;
        done_strobe = 0; tick = 0; clr_strobe = 0; irq_en = 2'b11;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1 reset state
        check("R1", count_now, 0);
        check("R1", timer_now, 0);
        check("R1", pending, 0);
        check("R1", irq, 0);
        m_cnt = 0; m_tmr = 0; m_pend = 0;

        // directed: threshold 3, delay 2
        step(1, 0, 0, 2'b00);            // R2 load 3
        step(0, 1, 1, 2'b00);            // R3 3->2, R5 timer 2, tick ignored
        step(0, 0, 1, 2'b00);            // R7 timer 1
        step(0, 0, 1, 2'b00);            // R8 expiry, counter back to 3
        check("R8", pending[1], 1);
        step(0, 0, 0, 2'b10);            // R9 clear delay bit
        check("R9", pending[1], 0);
        cfg_delay = 0;
        step(0, 1, 0, 2'b00);            // R6 timer held at 0
        step(0, 1, 0, 2'b00);
        step(0, 1, 0, 2'b01);            // R4 fires, R9 set beats clear
        check("R4", pending[0], 1);
        irq_en = 2'b10;
        step(0, 0, 0, 2'b00);
        check("R10", irq, 0);

        // sweep
        for (int thr = 0; thr <= 5; thr++)
            for (int dly = 0; dly <= 3; dly++)
                for (int en = 0; en < 4; en++) begin
                    cfg_threshold = 8'(thr); cfg_delay = 8'(dly); irq_en = 2'(en);
                    step(1, 0, 0, 2'b00);
                    for (int k = 0; k < 40; k++)
                        step(lfsr[15:11] == 0, lfsr[2] & lfsr[7], lfsr[4] | lfsr[9],
                             {lfsr[5] & lfsr[8] & lfsr[1], lfsr[3] & lfsr[6] & lfsr[0]});
                end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule